// File: doc/BRIEF.md
# Horizontal line timing generator for an analog TV encoder

This block produces the per-pixel horizontal timing of one video line. A pixel counter advances on each enabled clock and wraps at a programmable line total. From the count it decodes three gates: the sync pulse, the blanking interval and the colour-burst window. Sync always begins at count 0, and the other two gates are positioned by offsets counted from that point.

The configuration words are static inputs. The block captures them into a shadow copy under reset and again at each line wrap. Software can therefore rewrite them at any time without producing a line that mixes old and new timing. A one-clock line-start pulse marks each wrap, so a vertical sequencer can count lines.

Offsets are coded as "pixel index minus one". A blanking start value S therefore makes pixel S+1 the first blanked pixel. A blanking window whose end offset is below its start offset runs across the line wrap.

Top module: `hline_timer`

## Requirements
- R1: While `rst` is high at a rising edge, the count goes to 0, `line_start` goes to 0, and the current configuration inputs are captured as the active configuration.
- R2: On a rising edge with `pix_en` high and the count not equal to the active total, the count rises by one. With `pix_en` low, the count and `line_start` do not advance.
- R3: On a rising edge with `pix_en` high and the count equal to the active total, the count returns to 0. A line therefore lasts total+1 enabled pixels.
- R4: `line_start` is high for the clock that follows each wrapping edge, and low after every other edge.
- R5: `hsync` is high exactly when the count is below the active sync-end value. A sync-end of 0 gives no sync pulse.
- R6: When the active blank-end offset E is above the blank-start offset S, `hblank` is high exactly for counts S+1 through E.
- R7: When E is below S, `hblank` is high for counts of S+1 and above, and for counts from 0 through E, so the window spans the wrap.
- R8: When E equals S, `hblank` stays low.
- R9: With the active burst enable set, `burst_gate` is high exactly for counts from B+1 through B+L, where B is the burst offset and L is the burst length.
- R10: With the active burst enable clear, `burst_gate` stays low whatever the other burst fields hold.
- R11: Configuration inputs are applied only at a wrapping edge (or under reset). A change during a line leaves every output of that line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel clock enable |
| cfg_total | input | 13 | Pixels per line minus one |
| cfg_hs_end | input | 13 | Sync pulse length in pixels |
| cfg_burst_ofs | input | 13 | Burst start offset, pixels minus one |
| cfg_burst_len | input | 13 | Burst length in pixels |
| cfg_burst_en | input | 1 | Burst gate enable |
| cfg_blank_beg | input | 13 | Blank start offset, pixels minus one |
| cfg_blank_fin | input | 13 | Blank end offset, pixels minus one |
| hsync | output | 1 | Sync gate |
| hblank | output | 1 | Blanking gate |
| burst_gate | output | 1 | Colour-burst window |
| line_start | output | 1 | One-clock pulse after each wrap |
| pix_count | output | 13 | Current pixel index |

## Verification
`pix_count` and the three gates are decoded from state, so they reflect the rising edge just taken with no further delay. `line_start` is a register that is set by the same edge that clears the count. A configuration presented during a line first shows in the outputs on the clock after the wrapping edge.

The bench applies inputs at the falling edge. It then advances its reference model by exactly one rising edge and compares every output at the next falling edge. As a result, each comparison lines up with the edge that caused it.

// File: rtl/hline_pkg.sv
package hline_pkg;

    parameter int unsigned CNT_W = 13;
    localparam int unsigned EXT_W = CNT_W + 2;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [EXT_W-1:0] ext_t;

    typedef struct packed {
        cnt_t total;
        cnt_t hs_end;
        cnt_t burst_ofs;
        cnt_t burst_len;
        logic burst_en;
        cnt_t blank_beg;
        cnt_t blank_fin;
    } hcfg_t;

    typedef struct packed {
        logic hsync;
        logic hblank;
        logic burst;
    } hgate_t;

    // first pixel index of a window coded as offset minus one
    function automatic ext_t first_pix(cnt_t ofs);
        return ext_t'(ofs) + ext_t'(1);
    endfunction

    function automatic logic blank_hit(cnt_t p, cnt_t beg, cnt_t fin);
        ext_t pe;
        ext_t lo;
        ext_t hi;
        pe = ext_t'(p);
        lo = first_pix(beg);
        hi = first_pix(fin);
        if (lo == hi)
            return 1'b0;
        else if (lo < hi)
            return (pe >= lo) && (pe < hi);
        else
            return (pe >= lo) || (pe < hi);
    endfunction

    function automatic logic burst_hit(cnt_t p, cnt_t ofs, cnt_t len);
        ext_t pe;
        ext_t lo;
        pe = ext_t'(p);
        lo = first_pix(ofs);
        return (pe >= lo) && (pe < lo + ext_t'(len));
    endfunction

endpackage

// File: rtl/hline_shadow.sv
module hline_shadow
    import hline_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  hcfg_t cfg_in,
    output hcfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst || load)
            cfg_q <= cfg_in;
    end
endmodule

// File: rtl/hline_counter.sv
module hline_counter
    import hline_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pix_en,
    input  cnt_t total,
    output cnt_t count,
    output logic wrap,
    output logic line_start
);
    assign wrap = pix_en && (count == total);

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            line_start <= 1'b0;
        end else begin
            line_start <= wrap;
            if (wrap)
                count <= '0;
            else if (pix_en)
                count <= count + cnt_t'(1);
        end
    end
endmodule

// File: rtl/hline_decode.sv
module hline_decode
    import hline_pkg::*;
(
    input  cnt_t   count,
    input  hcfg_t  cfg,
    output hgate_t gates
);
    always_comb begin
        gates.hsync  = count < cfg.hs_end;
        gates.hblank = blank_hit(count, cfg.blank_beg, cfg.blank_fin);
        gates.burst  = cfg.burst_en && burst_hit(count, cfg.burst_ofs, cfg.burst_len);
    end
endmodule

// File: rtl/hline_timer.sv
module hline_timer
    import hline_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic [CNT_W-1:0] cfg_total,
    input  logic [CNT_W-1:0] cfg_hs_end,
    input  logic [CNT_W-1:0] cfg_burst_ofs,
    input  logic [CNT_W-1:0] cfg_burst_len,
    input  logic             cfg_burst_en,
    input  logic [CNT_W-1:0] cfg_blank_beg,
    input  logic [CNT_W-1:0] cfg_blank_fin,
    output logic             hsync,
    output logic             hblank,
    output logic             burst_gate,
    output logic             line_start,
    output logic [CNT_W-1:0] pix_count
);
    hcfg_t  cfg_w;
    hcfg_t  shd_q;
    hgate_t gates;
    cnt_t   count;
    logic   wrap;

    always_comb begin
        cfg_w.total     = cfg_total;
        cfg_w.hs_end    = cfg_hs_end;
        cfg_w.burst_ofs = cfg_burst_ofs;
        cfg_w.burst_len = cfg_burst_len;
        cfg_w.burst_en  = cfg_burst_en;
        cfg_w.blank_beg = cfg_blank_beg;
        cfg_w.blank_fin = cfg_blank_fin;
    end

    hline_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (wrap),
        .cfg_in (cfg_w),
        .cfg_q  (shd_q)
    );

    hline_counter u_counter (
        .clk        (clk),
        .rst        (rst),
        .pix_en     (pix_en),
        .total      (shd_q.total),
        .count      (count),
        .wrap       (wrap),
        .line_start (line_start)
    );

    hline_decode u_decode (
        .count (count),
        .cfg   (shd_q),
        .gates (gates)
    );

    assign hsync      = gates.hsync;
    assign hblank     = gates.hblank;
    assign burst_gate = gates.burst;
    assign pix_count  = count;
endmodule

// File: rtl/hline_chk.sv
module hline_chk
    import hline_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  pix_en,
    input cnt_t  pix_count,
    input logic  line_start,
    input logic  hsync,
    input logic  burst_gate,
    input hcfg_t act_cfg
);
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> $stable(pix_count) && !line_start);

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (pix_en && pix_count != act_cfg.total) |=> pix_count == $past(pix_count) + cnt_t'(1));

    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (pix_en && pix_count == act_cfg.total) |=> pix_count == '0 && line_start);

    a_r4_at_zero: assert property (@(posedge clk) disable iff (rst)
        line_start |-> pix_count == '0);

    a_r5_sync_head: assert property (@(posedge clk) disable iff (rst)
        (pix_count == '0 && act_cfg.hs_end != '0) |-> hsync);

    a_r10_burst_off: assert property (@(posedge clk) disable iff (rst)
        !act_cfg.burst_en |-> !burst_gate);

    a_r11_hold_cfg: assert property (@(posedge clk) disable iff (rst)
        !(pix_en && pix_count == act_cfg.total) |=> $stable(act_cfg));
endmodule

bind hline_timer hline_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_en     (pix_en),
    .pix_count  (pix_count),
    .line_start (line_start),
    .hsync      (hsync),
    .burst_gate (burst_gate),
    .act_cfg    (shd_q)
);

// File: tb/hline_timer_bench.sv
module hline_timer_bench;
    import hline_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, pix_en, c_ben;
    cnt_t c_total, c_hs, c_bofs, c_blen, c_hbs, c_hbe;
    logic hsync, hblank, burst_gate, line_start;
    cnt_t pix_count;

    hline_timer u_hline_timer (
        .clk(clk), .rst(rst), .pix_en(pix_en),
        .cfg_total(c_total), .cfg_hs_end(c_hs), .cfg_burst_ofs(c_bofs),
        .cfg_burst_len(c_blen), .cfg_burst_en(c_ben),
        .cfg_blank_beg(c_hbs), .cfg_blank_fin(c_hbe),
        .hsync(hsync), .hblank(hblank), .burst_gate(burst_gate),
        .line_start(line_start), .pix_count(pix_count)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    int seed_dummy;

    // reference model state
    int m_pix, m_ls;
    int s_total, s_hs, s_bofs, s_blen, s_ben, s_hbs, s_hbe;
    bit was_rst, pending;

    task automatic check(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int e_sync(int p);
        return (p < s_hs) ? 1 : 0;
    endfunction

    function automatic int e_blank(int p);
        int lo, hi;
        lo = s_hbs + 1;
        hi = s_hbe + 1;
        if (lo == hi) return 0;
        if (lo < hi) return (p >= lo && p < hi) ? 1 : 0;
        return (p >= lo || p < hi) ? 1 : 0;
    endfunction

    function automatic int e_burst(int p);
        if (s_ben == 0) return 0;
        return (p >= s_bofs + 1 && p < s_bofs + 1 + s_blen) ? 1 : 0;
    endfunction

    task automatic take_cfg();
        s_total = c_total; s_hs = c_hs; s_bofs = c_bofs; s_blen = c_blen;
        s_ben = c_ben; s_hbs = c_hbs; s_hbe = c_hbe;
    endtask

    // advance the model by one rising edge, then compare at the falling edge
    task automatic tick();
        bit wrap;
        string sfx;
        string btag;
        string ktag;
        was_rst = rst;
        pending = 0;
        if (rst) begin
            m_pix = 0; m_ls = 0; take_cfg();
        end else begin
            wrap = pix_en && (m_pix == s_total);
            m_ls = wrap ? 1 : 0;
            if (wrap) begin
                m_pix = 0; take_cfg();
            end else begin
                if (pix_en) m_pix++;
                pending = (c_total != s_total) || (c_hs != s_hs) || (c_bofs != s_bofs) ||
                          (c_blen != s_blen) || (c_ben != s_ben) || (c_hbs != s_hbs) ||
                          (c_hbe != s_hbe);
            end
        end
        @(negedge clk);
        sfx = was_rst ? " R1" : (pending ? " R11" : "");
        if (s_hbs == s_hbe) btag = "R8";
        else if (s_hbe < s_hbs) btag = "R7";
        else btag = "R6";
        ktag = (s_ben != 0) ? "R9" : "R10";
        check(int'(pix_count) == m_pix, {"R2/R3 pix_count", sfx}, int'(pix_count), m_pix);
        check(int'(line_start) == m_ls, {"R4 line_start", sfx}, int'(line_start), m_ls);
        check(int'(hsync) == e_sync(m_pix), {"R5 hsync", sfx}, int'(hsync), e_sync(m_pix));
        check(int'(hblank) == e_blank(m_pix), {btag, " hblank", sfx}, int'(hblank), e_blank(m_pix));
        check(int'(burst_gate) == e_burst(m_pix), {ktag, " burst_gate", sfx},
              int'(burst_gate), e_burst(m_pix));
    endtask

    task automatic set_cfg(int t, int hs, int bo, int bl, int be, int hb0, int hb1);
        c_total = cnt_t'(t); c_hs = cnt_t'(hs); c_bofs = cnt_t'(bo); c_blen = cnt_t'(bl);
        c_ben = be[0]; c_hbs = cnt_t'(hb0); c_hbe = cnt_t'(hb1);
    endtask

    task automatic rand_cfg(int maxtot);
        int t;
        t = $urandom_range(maxtot, 0);
        set_cfg(t, $urandom_range(t + 3, 0), $urandom_range(t + 3, 0),
                $urandom_range(t + 3, 0), $urandom_range(1, 0),
                $urandom_range(t + 3, 0), $urandom_range(t + 3, 0));
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        seed_dummy = $urandom(20240611);
        rst = 1'b1; pix_en = 1'b0;
        set_cfg(19, 3, 4, 4, 1, 1, 10);
        repeat (3) tick();                        // R1 reset state
        rst = 1'b0;
        pix_en = 1'b1;
        repeat (60) tick();                       // R2 R3 R5 R6 R9 directed
        for (int i = 0; i < 100; i++) begin       // R2 hold with gaps
            pix_en = $urandom_range(1, 0);
            tick();
        end
        pix_en = 1'b1;
        set_cfg(19, 5, 2, 6, 1, 15, 2);           // R7 wrapping blank, R11 mid-line
        repeat (60) tick();
        set_cfg(19, 0, 2, 6, 0, 7, 7);            // R8 empty blank, R10 burst off
        repeat (60) tick();
        set_cfg(0, 1, 0, 1, 1, 0, 0);             // single-pixel line
        repeat (12) tick();
        set_cfg(1, 1, 0, 1, 1, 1, 0);
        repeat (12) tick();
        for (int i = 0; i < 60; i++) begin        // R11 frequent mid-line rewrites
            rand_cfg(12);
            repeat (5) tick();
        end
        rst = 1'b1; tick(); rst = 1'b0;           // R1 reset in mid-run
        for (int i = 0; i < 40; i++) begin
            rand_cfg(150);
            for (int k = 0; k < 400; k++) begin
                pix_en = ($urandom_range(3, 0) != 0);
                tick();
            end
        end
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule